// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches eight external interrupt request pins and turns qualified activity on them into per-pin detect flags, per-pin request flags, one combined request toward the interrupt controller, and a wake-up indication for the low-power states. Each pin has its own 2-bit trigger selection: low level, high level, falling edge or rising edge. Every pin is brought into the clock domain by a two-flop synchronizer. A glitch filter then accepts a new pin value only after it has been sampled a fixed number of consecutive clock cycles. The filter window is counted in fast clock cycles, so it stays constant whatever the ratio between the fast clock and the system clock. Edge detection works on the filtered value.

Software reads the detect and request flags directly from the outputs, and reading has no side effects. It clears flags with a one-cycle write strobe and a bit mask. A detection that occurs in the same cycle as a clear wins. A level trigger that is still active therefore sets its flag again immediately.

The power-mode input selects which detections may wake the core. In the normal run state no wake-up is produced. In SLEEP any enabled detection wakes the core. In HALT only enabled level-triggered detections wake it, and the filter window is lengthened. In STOP the clock is assumed stopped, so wake-up is a combinational qualification of the raw pin level against an enabled level trigger.

Top module: `xirq_detector`

## Requirements
- R1: During reset and in the first cycle after it, all detect flags, all request flags and `irq_out` are 0.
- R2: In any power mode other than HALT, a pin value is accepted only after it has been sampled on 10 consecutive clock edges. A pulse lasting 9 cycles sets no flag, and a pulse lasting 10 cycles is detected.
- R3: In HALT (`pwr_mode` = 2'b10), the filter window is 22 consecutive samples. A 21-cycle pulse is ignored and a 22-cycle pulse is detected.
- R4: The trigger field for pin i is `trig_cfg[2i+1:2i]`. The codes are 00 = low level, 01 = high level, 10 = falling edge and 11 = rising edge. An edge sets the flag only on a transition of the filtered value in the selected direction.
- R5: Each clear write (`clr_wr` = 1) clears the detect and request flags of the pins set in `clr_mask`. A detection in the same cycle keeps the flag set, so a level trigger that is still active reads back as set on the cycle after the clear.
- R6: A detect flag is set whether or not the pin is enabled. The request flag is set only by a detection while `pin_en` is 1. `irq_out` is the OR over pins of detect flag AND enable.
- R7: A clear affects only the pins selected in `clr_mask`. Without a clear, a set flag stays set.
- R8: In SLEEP (`pwr_mode` = 2'b01), `wake_out` is 1 whenever any enabled pin has its detect flag set, whatever its trigger type.
- R9: In HALT, `wake_out` is produced only by enabled pins that have a level trigger and a set detect flag. Edge-configured pins never wake the core in this mode.
- R10: In STOP (`pwr_mode` = 2'b11), `wake_out` follows the raw pin combinationally. It is 1 when an enabled, level-configured pin is at its active level, and edge-configured or disabled pins never cause it.
- R11: In the run state (`pwr_mode` = 2'b00), `wake_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Raw external request pins |
| pin_en | input | 8 | Per-pin request and wake enable |
| trig_cfg | input | 16 | Two trigger-select bits per pin |
| pwr_mode | input | 2 | 00 run, 01 SLEEP, 10 HALT, 11 STOP |
| clr_wr | input | 1 | One-cycle flag clear strobe |
| clr_mask | input | 8 | Pins whose flags the clear affects |
| id_flags | output | 8 | Per-pin detect flags |
| ir_flags | output | 8 | Per-pin request flags |
| irq_out | output | 1 | Combined request to the interrupt controller |
| wake_out | output | 1 | Wake-up indication for the current power mode |

## Verification
The assertions assume that `pwr_mode`, `trig_cfg` and `pin_en` change only between clock edges. They also assume that the filter window in force is the one that the power mode of the previous cycle selected. The stimulus therefore drives every input on the falling clock edge. It changes the trigger configuration and the power mode only while the pins are held stable for longer than the longest window. Random patterns hold each pin level for 30 cycles, which exceeds the 22-cycle window plus the synchronizer. Only the directed pulses sit on the window boundaries.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_SLEEP = 2'b01,
        PM_HALT  = 2'b10,
        PM_STOP  = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        TRG_LOW  = 2'b00,
        TRG_HIGH = 2'b01,
        TRG_FALL = 2'b10,
        TRG_RISE = 2'b11
    } trig_e;

endpackage

// File: rtl/xirq_pin_filter.sv
module xirq_pin_filter #(
    parameter int FILT_RUN  = 10,
    parameter int FILT_HALT = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic long_win,
    output logic filt_o,
    output logic prev_o
);
    localparam int CNT_W = $clog2(FILT_HALT + 1);
    localparam logic [CNT_W-1:0] RUN_LAST  = CNT_W'(FILT_RUN - 1);
    localparam logic [CNT_W-1:0] HALT_LAST = CNT_W'(FILT_HALT - 1);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             filt;
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic [CNT_W-1:0] last_d;

    always_comb begin
        st_d      = st_q;
        last_d    = long_win ? HALT_LAST : RUN_LAST;
        st_d.s1   = pin_raw;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.filt;
        if (st_q.s2 == st_q.filt) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= last_d) begin
            st_d.filt = st_q.s2;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_o = st_q.filt;
    assign prev_o = st_q.prev;

    // R2 / R3: the filtered value moves only once the window has filled
    assert_filter_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.filt != $past(st_q.filt)) |->
        ($past(st_q.cnt) >= ($past(long_win) ? HALT_LAST : RUN_LAST)));

    // R2: the window counter never runs past the longest window
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= HALT_LAST);

endmodule

// File: rtl/xirq_trig_match.sv
module xirq_trig_match (
    input  logic [1:0] cfg,
    input  logic       filt,
    input  logic       prev,
    input  logic       raw,
    output logic       event_o,
    output logic       is_level_o,
    output logic       stop_hit_o
);
    import xirq_pkg::*;

    trig_e sel;

    always_comb begin
        sel        = trig_e'(cfg);
        is_level_o = (sel == TRG_LOW) || (sel == TRG_HIGH);
        unique case (sel)
            TRG_LOW:  event_o = ~filt;
            TRG_HIGH: event_o = filt;
            TRG_FALL: event_o = prev & ~filt;
            TRG_RISE: event_o = filt & ~prev;
            default:  event_o = 1'b0;
        endcase
        stop_hit_o = is_level_o && (raw == cfg[0]);
    end

endmodule

// File: rtl/xirq_detector.sv
module xirq_detector #(
    parameter int NUM_PINS  = 8,
    parameter int FILT_RUN  = 10,
    parameter int FILT_HALT = 22
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic [NUM_PINS-1:0]   pin_en,
    input  logic [2*NUM_PINS-1:0] trig_cfg,
    input  logic [1:0]            pwr_mode,
    input  logic                  clr_wr,
    input  logic [NUM_PINS-1:0]   clr_mask,
    output logic [NUM_PINS-1:0]   id_flags,
    output logic [NUM_PINS-1:0]   ir_flags,
    output logic                  irq_out,
    output logic                  wake_out
);
    import xirq_pkg::*;

    typedef struct packed {
        logic [NUM_PINS-1:0] id;
        logic [NUM_PINS-1:0] ir;
    } flag_st_t;

    flag_st_t fl_d, fl_q;
    pmode_e   mode;

    logic [NUM_PINS-1:0] filt_v, prev_v, evt_v, lvl_v, stop_v, clr_v;

    assign mode = pmode_e'(pwr_mode);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        xirq_pin_filter #(
            .FILT_RUN (FILT_RUN),
            .FILT_HALT(FILT_HALT)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_raw (pin_in[i]),
            .long_win(mode == PM_HALT),
            .filt_o  (filt_v[i]),
            .prev_o  (prev_v[i])
        );

        xirq_trig_match u_match (
            .cfg       (trig_cfg[2*i +: 2]),
            .filt      (filt_v[i]),
            .prev      (prev_v[i]),
            .raw       (pin_in[i]),
            .event_o   (evt_v[i]),
            .is_level_o(lvl_v[i]),
            .stop_hit_o(stop_v[i])
        );
    end

    always_comb begin
        clr_v   = clr_wr ? clr_mask : '0;
        fl_d.id = (fl_q.id & ~clr_v) | evt_v;
        fl_d.ir = (fl_q.ir & ~clr_v) | (evt_v & pin_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    always_comb begin
        unique case (mode)
            PM_SLEEP: wake_out = |(fl_q.id & pin_en);
            PM_HALT:  wake_out = |(fl_q.id & pin_en & lvl_v);
            PM_STOP:  wake_out = |(stop_v & pin_en);
            default:  wake_out = 1'b0;
        endcase
    end

    assign id_flags = fl_q.id;
    assign ir_flags = fl_q.ir;
    assign irq_out  = |(fl_q.id & pin_en);

    // R6: a request flag never stands without its detect flag
    assert_ir_within_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.ir & ~fl_q.id) == '0);

    // R7: without a clear write, set detect flags stay set
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((fl_q.id & $past(fl_q.id)) == $past(fl_q.id)));

    // R9: HALT wake needs an enabled, level-triggered, detected pin
    assert_halt_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_HALT && wake_out) |-> ((fl_q.id & pin_en & lvl_v) != '0));

    // R10: STOP wake needs an enabled level pin
    assert_stop_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_STOP && wake_out) |-> ((pin_en & lvl_v) != '0));

    // R11: no wake in the run state
    assert_run_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_RUN) |-> !wake_out);

endmodule

// File: tb/xirq_detector_test.sv
`timescale 1ns/1ps
module xirq_detector_test;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_en = '0;
    logic [2*NP-1:0] trig_cfg = {NP{2'b01}};
    logic [1:0]    pwr_mode = 2'b00;
    logic          clr_wr = 1'b0;
    logic [NP-1:0] clr_mask = '0;
    logic [NP-1:0] id_flags, ir_flags;
    logic          irq_out, wake_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xirq_detector uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_en(pin_en),
        .trig_cfg(trig_cfg), .pwr_mode(pwr_mode), .clr_wr(clr_wr),
        .clr_mask(clr_mask), .id_flags(id_flags), .ir_flags(ir_flags),
        .irq_out(irq_out), .wake_out(wake_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags(input logic [NP-1:0] m);
        clr_wr = 1'b1; clr_mask = m;
        tick(1);
        clr_wr = 1'b0; clr_mask = '0;
    endtask

    task automatic pulse(input int p, input int width);
        pin_in[p] = 1'b1;
        tick(width);
        pin_in[p] = 1'b0;
        tick(30);
    endtask

    // expected detect flags for one settle-clear-change sequence
    function automatic logic [NP-1:0] exp_id(input logic [2*NP-1:0] cfg,
                                             input logic [NP-1:0] o,
                                             input logic [NP-1:0] n);
        logic [NP-1:0] r = '0;
        for (int i = 0; i < NP; i++) begin
            case (cfg[2*i +: 2])
                2'b00: r[i] = !o[i] || !n[i];
                2'b01: r[i] = o[i] || n[i];
                2'b10: r[i] = o[i] && !n[i];
                default: r[i] = !o[i] && n[i];
            endcase
        end
        return r;
    endfunction

    task automatic run_all();
        logic [NP-1:0] o, n, e;
        void'($urandom(32'h1234_5678));
        // R1 reset state
        tick(2);
        check("R1 id in reset", id_flags, 0);
        check("R1 irq in reset", irq_out, 0);
        rst_n = 1'b1;
        tick(1);
        check("R1 id after reset", id_flags, 0);
        check("R1 ir after reset", ir_flags, 0);
        check("R1 irq after reset", irq_out, 0);

        // R2 normal window
        pin_en = 8'h01;
        pulse(0, 9);
        check("R2 9-cycle pulse ignored", id_flags[0], 0);
        pulse(0, 10);
        check("R2 10-cycle pulse detected", id_flags[0], 1);
        check("R6 ir set when enabled", ir_flags[0], 1);
        clear_flags(8'hFF);
        check("R5 clear after idle", id_flags, 0);

        // R3 HALT window and R9 HALT wake
        pwr_mode = 2'b10;
        pulse(0, 21);
        check("R3 21-cycle pulse ignored", id_flags[0], 0);
        check("R9 no wake without detect", wake_out, 0);
        pulse(0, 22);
        check("R3 22-cycle pulse detected", id_flags[0], 1);
        check("R9 level wake in HALT", wake_out, 1);
        clear_flags(8'hFF);
        check("R9 wake drops after clear", wake_out, 0);
        trig_cfg[3:2] = 2'b11; pin_en = 8'h02;
        pulse(1, 30);
        check("R4 rising edge detected", id_flags[1], 1);
        check("R9 edge pin no wake in HALT", wake_out, 0);

        // R8 SLEEP
        pwr_mode = 2'b01;
        #1 check("R8 edge wake in SLEEP", wake_out, 1);
        // R11 run
        pwr_mode = 2'b00;
        #1 check("R11 no wake in run", wake_out, 0);
        tick(1);
        clear_flags(8'hFF);

        // R10 STOP
        pwr_mode = 2'b11; pin_en = 8'h04;
        pin_in[2] = 1'b1;
        #1 check("R10 raw high wakes in STOP", wake_out, 1);
        pin_en = 8'h00;
        #1 check("R10 disabled pin no wake", wake_out, 0);
        pin_en = 8'h04; trig_cfg[5:4] = 2'b11;
        #1 check("R10 edge cfg no wake", wake_out, 0);
        trig_cfg[5:4] = 2'b00; pin_in[2] = 1'b0;
        #1 check("R10 low level wakes in STOP", wake_out, 1);
        tick(1);
        trig_cfg[5:4] = 2'b01; pin_en = 8'h00; pwr_mode = 2'b00;
        tick(30);
        clear_flags(8'hFF);

        // R6 disabled pin sets id only
        pin_in[3] = 1'b1;
        tick(15);
        check("R6 id set while disabled", id_flags[3], 1);
        check("R6 ir clear while disabled", ir_flags[3], 0);
        check("R6 irq low while disabled", irq_out, 0);
        pin_en = 8'h08;
        #1 check("R6 irq follows enable", irq_out, 1);
        // R5 level re-set after clear
        clear_flags(8'h08);
        check("R5 active level re-sets", id_flags[3], 1);
        pin_in[3] = 1'b0; tick(15);
        clear_flags(8'h08);
        check("R5 idle level cleared", id_flags[3], 0);

        // R7 partial clear, R4 falling edge
        trig_cfg[9:8] = 2'b11; trig_cfg[11:10] = 2'b10;
        pin_in[5] = 1'b1; tick(15);
        pin_in[4] = 1'b1; pin_in[5] = 1'b0; tick(15);
        check("R4 falling edge detected", id_flags[5], 1);
        clear_flags(8'h10);
        check("R7 masked pin cleared", id_flags[4], 0);
        check("R7 unmasked pin kept", id_flags[5], 1);
        pin_in = '0; tick(15);

        // random patterns in the run state
        for (int k = 0; k < 40; k++) begin
            trig_cfg = 16'($urandom);
            pin_en = 8'($urandom);
            o = 8'($urandom);
            n = 8'($urandom);
            pin_in = o; tick(30);
            clear_flags(8'hFF); tick(2);
            pin_in = n; tick(30);
            e = exp_id(trig_cfg, o, n);
            check("R4 random detect flags", id_flags, e);
            check("R6 random request flags", ir_flags, e & pin_en);
            check("R6 random irq", irq_out, |(e & pin_en));
            check("R11 random run wake", wake_out, 0);
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL R1 watchdog actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule